// File: doc/BRIEF.md
# Interpolated Table Arcsine Evaluator

The block turns an unsigned fixed-point operand in [0, 1) into its arcsine, in radians, as a signed fixed-point word. The upper bits of the operand pick one of 1024 evenly spaced sample points. The lower bits give the distance past that point. Two constant tables are built at elaboration by integer arithmetic alone. One holds the arcsine at each sample point. The other holds the step from that point to the next one. The result is the sample value plus the step scaled by the distance, so the output traces a straight line between neighbouring samples rather than a staircase.

Operands stream in with a qualifying strobe and no back-pressure. Any mix of busy and idle cycles is accepted. Each qualified operand produces one qualified result a fixed number of clocks later, in the same order the operands arrived. The sum is clamped to the 16-bit signed range, so it never wraps.

Top module: `asin_interp`

## Requirements
- R1: While `rst` is high, and on the first clock edge that samples it high, `outValid` is 0 and `outData` is 0.
- R2: `outValid` is high on the third rising edge after an edge that sampled `inValid` high, and low after an edge whose input three edges earlier was not qualified.
- R3: On every cycle with `outValid` low, `outData` keeps the value it held on the cycle before.
- R4: `inData` is 18 bits wide. Bits [17:8] are the index i, read as an unsigned integer truncated toward zero. Bits [7:0] are the remainder f, read as the unsigned fraction f/256.
- R5: The table entry T[i] is arcsin(i/1024) in signed Q2.14, meaning the value times 16384, within 2 LSB of the rounded ideal.
- R6: When the remainder is 0, the result is exactly T[i].
- R7: For i below 1023, the result is T[i] + floor((T[i+1] − T[i]) · f / 256). The step is taken as a signed full-width product and then shifted arithmetically right by 8.
- R8: At index 1023 the stored step is 0, so the result is T[1023] for every remainder.
- R9: The sum saturates at 32767 and −32768 rather than wrapping. Each result lies between T[i] and T[i] + step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies `inData` on this edge |
| inData | input | 18 | Operand: index in [17:8], remainder in [7:0] |
| outValid | output | 1 | Qualifies `outData` |
| outData | output | 16 | Arcsine result, signed Q2.14 |

## Verification
Every result is due on the third rising edge after the edge that captured its operand. The bench drives inputs on falling edges and keeps a three-deep record of what it drove. At each falling edge it compares the outputs against the entry driven three falling edges earlier, so a bubble there must show `outValid` low and an unchanged `outData`. A first sweep at zero remainder over every index records T[i] and checks it against arcsine computed in real arithmetic. Later random and directed operands are held exactly to the interpolation formula built on those recorded entries. The checker compares each result with the stage-one table values from two cycles earlier.

// File: rtl/asin_pkg.sv
package asin_pkg;

  localparam int IDX_W  = 10;
  localparam int FRAC_W = 8;
  localparam int DATA_W = 16;
  localparam int Q_FRAC = 14;
  localparam int IN_W   = IDX_W + FRAC_W;
  localparam int DEPTH  = 1 << IDX_W;

  // stage load strobes issued by the control to the datapath
  typedef struct packed {
    logic rdEn;
    logic mulEn;
    logic sumEn;
  } stageStrobe_t;

  // sine of a Q30 angle by a truncated Taylor series
  function automatic longint sinQ30(input longint ang);
    longint acc;
    longint term;
    acc  = ang;
    term = ang;
    for (int k = 1; k <= 11; k++) begin
      term = -((((term * ang) >>> 30) * ang) >>> 30) / longint'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // arcsine of idx/DEPTH in Q(Q_FRAC), found by bisection on the sine
  function automatic int asinEntry(input int idx);
    longint lo;
    longint hi;
    longint mid;
    longint target;
    lo     = 0;
    hi     = 64'd1686629714;
    target = longint'(idx) <<< (30 - IDX_W);
    for (int n = 0; n < 32; n++) begin
      mid = (lo + hi) >>> 1;
      if (sinQ30(mid) <= target) lo = mid;
      else hi = mid;
    end
    return int'((lo + (64'sd1 <<< (29 - Q_FRAC))) >>> (30 - Q_FRAC));
  endfunction

endpackage

// File: rtl/asin_ctrl.sv
module asin_ctrl
  import asin_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);

  localparam int STAGES = 3;

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strobe.rdEn  = inValid;
    strobe.mulEn = validPipe[0];
    strobe.sumEn = validPipe[1];
  end

  assign outValid = validPipe[STAGES-1];

endmodule

// File: rtl/asin_datapath.sv
module asin_datapath
  import asin_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  stageStrobe_t             strobe,
  input  logic [IN_W-1:0]          inData,
  output logic signed [DATA_W-1:0] outData
);

  localparam int PROD_W = DATA_W + FRAC_W + 1;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(1 << (DATA_W - 1));

  logic signed [DATA_W-1:0] sampleRom [DEPTH];
  logic signed [DATA_W-1:0] stepRom   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gRom
    localparam int SAMPLE = asinEntry(g);
    localparam int STEP   = (g == DEPTH - 1) ? 0 : asinEntry(g + 1) - SAMPLE;
    assign sampleRom[g] = DATA_W'(SAMPLE);
    assign stepRom[g]   = DATA_W'(STEP);
  end

  logic [IDX_W-1:0]  idx;
  logic [FRAC_W-1:0] frac;
  assign idx  = inData[IN_W-1:FRAC_W];
  assign frac = inData[FRAC_W-1:0];

  // stage 1: table read
  logic signed [DATA_W-1:0] baseS1;
  logic signed [DATA_W-1:0] slopeS1;
  logic [FRAC_W-1:0]        fracS1;
  // stage 2: multiply
  logic signed [DATA_W-1:0] baseS2;
  logic signed [PROD_W-1:0] prodS2;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseS1  <= '0;
      slopeS1 <= '0;
      fracS1  <= '0;
    end else if (strobe.rdEn) begin
      baseS1  <= sampleRom[idx];
      slopeS1 <= stepRom[idx];
      fracS1  <= frac;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseS2 <= '0;
      prodS2 <= '0;
    end else if (strobe.mulEn) begin
      baseS2 <= baseS1;
      prodS2 <= PROD_W'(slopeS1) * $signed({1'b0, fracS1});
    end
  end

  // stage 3: add and clamp
  logic signed [SUM_W-1:0] sumFull;
  logic signed [DATA_W-1:0] sumSat;
  always_comb begin
    sumFull = SUM_W'(baseS2) + SUM_W'(prodS2 >>> FRAC_W);
    if (sumFull > MAX_V)      sumSat = MAX_V[DATA_W-1:0];
    else if (sumFull < MIN_V) sumSat = MIN_V[DATA_W-1:0];
    else                      sumSat = sumFull[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)              outData <= '0;
    else if (strobe.sumEn) outData <= sumSat;
  end

endmodule

// File: rtl/asin_interp.sv
module asin_interp
  import asin_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic [IN_W-1:0]          inData,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outData
);

  stageStrobe_t strobe;

  asin_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  asin_datapath uDp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/asin_interp_chk.sv
module asin_interp_chk
  import asin_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic                     inValid,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outData,
  input logic signed [DATA_W-1:0] baseS1,
  input logic signed [DATA_W-1:0] slopeS1,
  input logic [FRAC_W-1:0]        fracS1
);

  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!outValid && outData == '0));

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd0 && !outValid) |-> $stable(outData));

  assert_zero_frac_exact_R6: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && outValid && $past(fracS1, 2) == '0) |-> (outData == $past(baseS1, 2)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2 && outValid) |->
      ((DATA_W+1)'(outData) >= (DATA_W+1)'($past(baseS1, 2)) &&
       (DATA_W+1)'(outData) <= (DATA_W+1)'($past(baseS1, 2)) + (DATA_W+1)'($past(slopeS1, 2))));

endmodule

bind asin_interp asin_interp_chk uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outData  (outData),
  .baseS1   (uDp.baseS1),
  .slopeS1  (uDp.slopeS1),
  .fracS1   (uDp.fracS1)
);

// File: tb/tb_asin_interp.sv
module tb_asin_interp;

  localparam int DEPTH = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [17:0] inData = '0;
  logic outValid;
  logic signed [15:0] outData;

  always #10 clk = ~clk;

  asin_interp dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  typedef struct {
    bit v;
    int idx;
    int frac;
    int kind; // 0 record entry, 1 interpolate, 2 exact repeat
  } slot_t;

  int tests = 0;
  int fails = 0;
  int rec [DEPTH];
  slot_t pipe [3];
  logic signed [15:0] lastOut = '0;
  bit done = 0;

  function automatic int idealQ14(input int i);
    real a;
    a = $asin(real'(i) / 1024.0) * 16384.0;
    return int'(a);
  endfunction

  function automatic int interpExp(input int i, input int f);
    int step;
    int e;
    step = (i == DEPTH - 1) ? 0 : rec[i + 1] - rec[i];
    e = rec[i] + ((step * f) >>> 8);
    if (e > 32767) e = 32767;
    if (e < -32768) e = -32768;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOutputs();
    slot_t s;
    int e;
    s = pipe[2];
    if (s.v) begin
      check(outValid == 1'b1, "R2", int'(outValid), 1);
      if (s.kind == 0) begin
        rec[s.idx] = int'(outData);
        e = idealQ14(s.idx);
        // R5 table sample, R6 zero remainder path
        check((int'(outData) - e) <= 2 && (e - int'(outData)) <= 2, "R5", int'(outData), e);
      end else if (s.kind == 2) begin
        check(int'(outData) == rec[s.idx], "R6", int'(outData), rec[s.idx]);
      end else begin
        e = interpExp(s.idx, s.frac);
        if (s.idx == DEPTH - 1)
          check(int'(outData) == rec[DEPTH - 1], "R8", int'(outData), rec[DEPTH - 1]);
        else
          check(int'(outData) == e, "R7/R9", int'(outData), e);
      end
    end else begin
      check(outValid == 1'b0, "R2", int'(outValid), 0);
      check(outData == lastOut, "R3", int'(outData), int'(lastOut));
    end
    lastOut = outData;
  endtask

  task automatic step(input bit v, input int i, input int f, input int kind);
    @(negedge clk);
    checkOutputs();
    pipe[2] = pipe[1];
    pipe[1] = pipe[0];
    pipe[0] = '{v, i, f, kind};
    inValid = v;
    inData = {i[9:0], f[7:0]};
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3; k++) pipe[k] = '{0, 0, 0, 0};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(outData == 16'sd0, "R1", int'(outData), 0);
    rst = 1'b0;
    // sweep every index at zero remainder, with random bubbles
    for (int i = 0; i < DEPTH; i++) begin
      if ($urandom_range(0, 7) == 0) step(0, 0, $urandom_range(0, 255), 0);
      step(1, i, 0, 0);
    end
    // directed corners: R4 truncation (31 + 0.723), R8 last index, R6 repeats
    step(1, 31, 185, 1);
    step(1, 1023, 255, 1);
    step(1, 1023, 1, 1);
    step(1, 1022, 255, 1);
    step(1, 0, 255, 1);
    step(1, 512, 0, 2);
    step(1, 1023, 0, 2);
    step(0, 7, 7, 0);
    step(0, 9, 9, 0);
    // random operands mixed with idle cycles
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) step(0, $urandom_range(0, 1023), $urandom_range(0, 255), 0);
      else step(1, $urandom_range(0, 1023), $urandom_range(0, 255), 1);
    end
    for (int n = 0; n < 4; n++) step(0, 0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule